// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer

This block sits behind the serial front end of a byte-wide serial EEPROM. It collects the data bytes of one page write command in a local page-sized buffer. When chip select rises, it commits the collected bytes to the memory array in one self-timed write. The front end passes it decoded events, all synchronous to `clk_i`:
- a command-start strobe with the 16-bit start address;
- a strobe for each complete data byte;
- a chip-select rising-edge event, qualified by whether that edge fell on a whole-byte boundary.

Protection decoding and the write-enable latch live outside the block. They arrive here as two level inputs: a protect-hit flag and a write-enable flag.

The buffer loads bytes at a six-bit offset that wraps within the addressed page. If more bytes arrive than fit in a page, the newest ones therefore overwrite the oldest. A per-byte mask records which offsets were loaded.

Once a commit is accepted, the block holds `busy_o` for a fixed number of clock cycles. During the first page-size cycles of that window it scans offsets in ascending order and issues one array write strobe for each loaded offset. Offsets that were not loaded keep their old array contents. A one-cycle pulse then tells the enable latch to clear.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy_o`, `mem_we_o` and `wen_clr_o` are 0.
- R2: Every array write of a commit carries page bits `mem_addr_o[14:6]` equal to `addr_i[14:6]` of the command; `addr_i[15]` has no effect.
- R3: The load offset starts at `addr_i[5:0]` and increments by one per accepted byte, wrapping from 63 to 0 within the same page.
- R4: When more than 64 bytes are loaded, each offset holds the last byte loaded at it, so the 64 most recent bytes are the ones written.
- R5: A commit writes only the offsets that were loaded, each exactly once, one per cycle in ascending offset order, with `mem_addr_o[5:0]` the offset and `mem_wdata_o` the loaded byte.
- R6: A chip-select rise with `cs_aligned_i`=0 abandons the command: no array write and no busy period.
- R7: A chip-select rise after a command with zero data bytes loaded starts no write.
- R8: A chip-select rise with `wen_i`=0 or `protect_hit_i`=1 starts no write, and `wen_clr_o` stays 0.
- R9: An accepted commit raises `busy_o` in the cycle after the chip-select rise event and holds it for exactly WRITE_CYCLES cycles.
- R10: `wen_clr_o` pulses for one cycle, in the cycle right after `busy_o` falls, and only after an accepted commit.
- R11: While `busy_o` is 1, the inputs `cmd_start_i`, `byte_valid_i` and `cs_rise_i` are ignored; the ongoing commit writes exactly the bytes that were loaded before it.
- R12: Bytes and chip-select rises that arrive without a preceding command start (after a commit or an abandon) are ignored and start no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Page write command decoded, address valid |
| addr_i | input | 16 | Command start address |
| byte_valid_i | input | 1 | One data byte received |
| byte_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select rose this cycle |
| cs_aligned_i | input | 1 | The chip-select rise fell on a byte boundary |
| wen_i | input | 1 | Write-enable latch state |
| protect_hit_i | input | 1 | Command page lies in a protected area |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_addr_o | output | 15 | Array byte address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Self-timed write in progress |
| wen_clr_o | output | 1 | Clear request for the write-enable latch |

## Verification
The load path is tried with several patterns, each of which separates one behaviour from the others:
- short runs in the middle of a page show a correct offset and mask;
- runs that start near offset 63 show wrapping as distinct from carrying into the page bits;
- runs longer than a page show last-writer-wins as distinct from first-writer-wins;
- a start address with bit 15 set shows that this bit is dropped.

The commit gate is driven with each reject condition on its own: a misaligned edge, zero bytes, enable low, and a protect hit. This tells each gate term apart.

Random transactions mix lengths, gaps-free bursts and gate inputs. A noise pattern injected during busy separates inputs that are ignored from inputs that corrupt the buffer or mask.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_DATA_W = 8;
  typedef logic [PWB_DATA_W-1:0] pwb_byte_t;
endpackage

// File: rtl/pwb_loader.sv
module pwb_loader
  import pwb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  open_i,
  input  logic [OFS_W-1:0]      start_ofs_i,
  input  logic                  wr_i,
  input  pwb_byte_t             data_i,
  input  logic [OFS_W-1:0]      rd_idx_i,
  output pwb_byte_t             rd_data_o,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic                  any_o
);
  pwb_byte_t             mem_q [PAGE_BYTES];
  logic [OFS_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  any_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      mask_q <= '0;
      any_q  <= 1'b0;
    end else if (open_i) begin
      ptr_q  <= start_ofs_i;
      mask_q <= '0;
      any_q  <= 1'b0;
    end else if (wr_i) begin
      ptr_q         <= ptr_q + 1'b1;  // wraps inside the page
      mask_q[ptr_q] <= 1'b1;
      any_q         <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign mask_o    = mask_q;
  assign any_o     = any_q;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned CYCLES = 1000,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == CNT_W'(CYCLES - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned PAGE_BYTES   = 64,
  parameter int unsigned WRITE_CYCLES = 1000,
  localparam int unsigned OFS_W  = $clog2(PAGE_BYTES),
  localparam int unsigned MEM_AW = ADDR_W - 1,
  localparam int unsigned PAGE_W = MEM_AW - OFS_W,
  localparam int unsigned CNT_W  = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              wen_i,
  input  logic              protect_hit_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o,
  output logic              wen_clr_o
);
  logic                  busy, active_q, open, wr, commit, any, in_scan;
  logic [PAGE_W-1:0]     page_q;
  logic [PAGE_BYTES-1:0] mask;
  logic [CNT_W-1:0]      cnt;
  logic [OFS_W-1:0]      scan_idx;
  pwb_byte_t             rd_data;
  logic                  unused_top_bit;

  assign unused_top_bit = addr_i[ADDR_W-1];

  assign open   = cmd_start_i && !busy;
  assign wr     = byte_valid_i && active_q && !busy && !cmd_start_i;
  assign commit = cs_rise_i && active_q && !busy && cs_aligned_i && any
                  && wen_i && !protect_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      page_q   <= '0;
    end else if (open) begin
      active_q <= 1'b1;
      page_q   <= addr_i[MEM_AW-1:OFS_W];
    end else if (cs_rise_i && !busy) begin
      active_q <= 1'b0;  // command ends, committed or abandoned
    end
  end

  pwb_loader #(.PAGE_BYTES(PAGE_BYTES)) u_loader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (open),
    .start_ofs_i(addr_i[OFS_W-1:0]),
    .wr_i       (wr),
    .data_i     (byte_i),
    .rd_idx_i   (scan_idx),
    .rd_data_o  (rd_data),
    .mask_o     (mask),
    .any_o      (any)
  );

  pwb_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (busy),
    .cnt_o  (cnt),
    .done_o (wen_clr_o)
  );

  // scan the page during the first PAGE_BYTES cycles of the busy window
  assign scan_idx    = cnt[OFS_W-1:0];
  assign in_scan     = busy && (cnt < CNT_W'(PAGE_BYTES));
  assign mem_we_o    = in_scan && mask[scan_idx];
  assign mem_addr_o  = {page_q, scan_idx};
  assign mem_wdata_o = rd_data;
  assign busy_o      = busy;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned MEM_AW = 15,
  parameter int unsigned OFS_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_rise_i,
  input logic              cs_aligned_i,
  input logic              wen_i,
  input logic              protect_hit_i,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              wen_clr_o
);
  assert_we_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_busy_after_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i));

  assert_clr_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |-> (!busy_o && $past(busy_o)));

  assert_misaligned_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !cs_aligned_i && !busy_o) |=> !busy_o);

  assert_gate_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !busy_o && (!wen_i || protect_hit_i)) |=> !busy_o);

  assert_page_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[MEM_AW-1:OFS_W]));
endmodule

bind page_write_buffer pwb_checker #(.MEM_AW(MEM_AW), .OFS_W(OFS_W)) u_pwb_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_rise_i    (cs_rise_i),
  .cs_aligned_i (cs_aligned_i),
  .wen_i        (wen_i),
  .protect_hit_i(protect_hit_i),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .busy_o       (busy_o),
  .wen_clr_o    (wen_clr_o)
);

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WC = 100;
  localparam int PB = 64;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cmd_start_i = 0, byte_valid_i = 0, cs_rise_i = 0;
  logic        cs_aligned_i = 0, wen_i = 0, protect_hit_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic        mem_we_o, busy_o, wen_clr_o;
  logic [14:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_data [PB];
  bit         exp_mask [PB];
  bit         seen     [PB];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_buffer #(.WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_start_i(cmd_start_i), .addr_i(addr_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .cs_rise_i(cs_rise_i),
    .cs_aligned_i(cs_aligned_i), .wen_i(wen_i), .protect_hit_i(protect_hit_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .busy_o(busy_o), .wen_clr_o(wen_clr_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit commit_expected(int n, bit al, bit we, bit pr);
    return al && (n > 0) && we && !pr;
  endfunction

  function automatic int exp_count();
    int c = 0;
    for (int i = 0; i < PB; i++) c += exp_mask[i];
    return c;
  endfunction

  // one command: address, n bytes, then the chip-select rise and its outcome
  task automatic run_tx(input logic [15:0] a, input int n, input bit al,
                        input bit we, input bit pr, input bit noise, input bit with_cmd);
    logic [5:0] ptr;
    bit ec;
    int busy_n = 0, clr_n = 0, clr_at = -1, wr_n = 0, last = -1;
    ec = with_cmd && commit_expected(n, al, we, pr);
    if (with_cmd) begin
      for (int i = 0; i < PB; i++) exp_mask[i] = 0;
      cmd_start_i = 1; addr_i = a;
      @(negedge clk); cmd_start_i = 0;
    end
    ptr = a[5:0];
    for (int i = 0; i < n; i++) begin
      byte_valid_i = 1; byte_i = 8'($urandom);
      exp_data[ptr] = byte_i; exp_mask[ptr] = 1; ptr = ptr + 1'b1;
      @(negedge clk);
    end
    byte_valid_i = 0;
    for (int i = 0; i < PB; i++) seen[i] = 0;
    cs_rise_i = 1; cs_aligned_i = al; wen_i = we; protect_hit_i = pr;
    for (int j = 0; j <= WC + 2; j++) begin
      @(negedge clk);
      cs_rise_i = 0; byte_valid_i = 0; cmd_start_i = 0;
      if (noise && ec) begin
        if (j == 1) begin byte_valid_i = 1; byte_i = 8'hA5; end
        if (j == 3) begin cmd_start_i = 1; addr_i = 16'h0000; end
        if (j == 5) begin cs_rise_i = 1; cs_aligned_i = 1; wen_i = 1; protect_hit_i = 0; end
        if (j == 7) byte_valid_i = 1;
      end
      if (busy_o) busy_n++;
      if (wen_clr_o) begin clr_n++; clr_at = j; end
      if (mem_we_o) begin
        int off;
        off = int'(mem_addr_o[5:0]);
        wr_n++;
        chk(ec, "R6/R7/R8/R12 unexpected write", 1, 0);
        chk(mem_addr_o[14:6] == a[14:6], "R2 page", int'(mem_addr_o[14:6]), int'(a[14:6]));
        chk(exp_mask[off] && !seen[off] && off > last, "R5 offset set/order", off, last + 1);
        chk(mem_wdata_o == exp_data[off], "R3/R4/R11 data", int'(mem_wdata_o), int'(exp_data[off]));
        seen[off] = 1; last = off;
      end
    end
    cs_rise_i = 0; byte_valid_i = 0; cmd_start_i = 0;
    chk(busy_n == (ec ? WC : 0), "R9 busy length", busy_n, ec ? WC : 0);
    chk(clr_n == (ec ? 1 : 0), "R10 clear pulse count", clr_n, ec ? 1 : 0);
    if (ec) chk(clr_at == WC, "R10 clear pulse timing", clr_at, WC);
    chk(wr_n == (ec ? exp_count() : 0), "R5 write count", wr_n, ec ? exp_count() : 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy_o && !mem_we_o && !wen_clr_o, "R1 reset outputs",
        int'({busy_o, mem_we_o, wen_clr_o}), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!busy_o && !mem_we_o && !wen_clr_o, "R1 after release",
        int'({busy_o, mem_we_o, wen_clr_o}), 0);
    run_tx(16'h8040, 3, 1, 1, 0, 0, 1);   // R2 bit 15 dropped
    run_tx(16'h123E, 5, 1, 1, 0, 0, 1);   // R3 wrap 62..2
    run_tx(16'h2A4A, 70, 1, 1, 0, 0, 1);  // R4 overrun
    run_tx(16'h0100, 4, 0, 1, 0, 0, 1);   // R6 misaligned
    run_tx(16'h0100, 0, 1, 1, 0, 0, 1);   // R7 empty
    run_tx(16'h0200, 4, 1, 0, 0, 0, 1);   // R8 enable low
    run_tx(16'h0300, 4, 1, 1, 1, 0, 1);   // R8 protect hit
    run_tx(16'h0400, 6, 1, 1, 0, 0, 1);
    run_tx(16'h0400, 6, 1, 1, 0, 0, 0);   // R12 no command
    run_tx(16'h7FC0, 64, 1, 1, 0, 1, 1);  // R11 noise during busy
    for (int t = 0; t < 30; t++) begin
      bit al, we, pr;
      al = ($urandom % 8) != 0; we = ($urandom % 6) != 0; pr = ($urandom % 6) == 0;
      run_tx(16'($urandom), int'($urandom % 140), al, we, pr, ($urandom % 2) == 1, 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule